// File: doc/BRIEF.md
# Multi-Digit Decimal Adder

This block adds two packed decimal numbers, each holding `NUM_DIGITS` digits of four bits (default three), together with a one-bit carry-in. It returns a packed decimal sum of the same width and a decimal carry-out. Digit k sits in bits `[4k+3:4k]` of every packed bus, so digit 0 is the least significant.

Each digit position has its own slice. A slice first adds its two digits and its incoming carry in plain binary, which gives a five-bit intermediate value. When that value is above nine, the slice adds six to the low nibble. The flag that triggers this adjustment is also the carry passed to the next digit up, so the slices form a ripple chain. The most significant slice's flag is the final carry-out.

A parameter chooses between two output forms. With the default setting, the result is captured into an output register on each cycle where `inValid` is high, and `outValid` follows one cycle later. With the register removed, the outputs are a direct combinational function of the inputs. Input digits in the range 1010 to 1111 are outside the contract.

Top module: `bcd_adder_top`

## Requirements
- R1: When a digit's binary total (digit A + digit B + incoming carry) is 9 or less, that total is the result digit and the digit's carry is 0.
- R2: When a digit's binary total is between 10 and 19, the result digit is the low four bits of (total + 6), the carry out of that addition is dropped, and the digit's carry is 1.
- R3: Each digit's carry is the carry-in of the next more significant digit; for example, 999 + 001 gives 000.
- R4: `carryIn` is added into digit 0 only.
- R5: `carryOut` equals the carry of the most significant digit (for example, 500 + 500 gives 000 with `carryOut` = 1).
- R6: With the output register present, the sum and carry for inputs presented in a cycle with `inValid` = 1 appear on the outputs after the next rising clock edge. `outValid` is 1 in exactly the cycle that follows each such cycle.
- R7: With the output register present, a cycle with `inValid` = 0 leaves `sumOut` and `carryOut` unchanged, whatever the data inputs are.
- R8: While `rstN` is low, `sumOut`, `carryOut` and `outValid` are all 0.
- R9: For decimal inputs, every four-bit digit of `sumOut` is 9 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low reset, synchronous |
| inValid | input | 1 | Marks the operands in this cycle for capture |
| aIn | input | 4*NUM_DIGITS | First operand, packed decimal |
| bIn | input | 4*NUM_DIGITS | Second operand, packed decimal |
| carryIn | input | 1 | Carry into digit 0 |
| sumOut | output | 4*NUM_DIGITS | Packed decimal sum |
| carryOut | output | 1 | Decimal carry out of the top digit |
| outValid | output | 1 | High in the cycle after a capture |

## Verification
With the default registered output, every sum, carry and valid result is due exactly one rising edge after the cycle in which its operands are driven with `inValid` high. The bench drives operands on a falling edge and samples on the following falling edge, so exactly one capture edge lies between driving and sampling. Hold behaviour is checked two falling edges after operands are changed with `inValid` low, which lets a wrongly enabled capture show up. The reset state is sampled while reset is still held low.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;

  localparam int DIGIT_BITS = 4;

  // strobes sent from control to datapath
  typedef struct packed {
    logic capture;
  } adderStrobes_t;

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice (
  input  logic [3:0] digA,
  input  logic [3:0] digB,
  input  logic       cIn,
  output logic [3:0] digSum,
  output logic       cOut
);
  logic [4:0] binTotal;
  logic [3:0] adjusted;
  logic       needFix;

  always_comb begin
    binTotal = {1'b0, digA} + {1'b0, digB} + {4'b0000, cIn};
    // totals 10..19 need the decimal adjustment
    needFix  = binTotal[4] | (binTotal[3] & (binTotal[2] | binTotal[1]));
    adjusted = binTotal[3:0] + 4'b0110; // carry of this add is dropped
    digSum   = needFix ? adjusted : binTotal[3:0];
    cOut     = needFix;
  end
endmodule

// File: rtl/bcd_adder_ctrl.sv
module bcd_adder_ctrl
  import bcd_adder_pkg::*;
#(
  parameter bit REGISTER_OUTPUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output adderStrobes_t strobes,
  output logic          outValid
);
  always_comb strobes.capture = inValid & rstN;

  generate
    if (REGISTER_OUTPUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
    end else begin : g_comb
      assign outValid = inValid & rstN;
    end
  endgenerate
endmodule

// File: rtl/bcd_adder_datapath.sv
module bcd_adder_datapath
  import bcd_adder_pkg::*;
#(
  parameter int NUM_DIGITS      = 3,
  parameter bit REGISTER_OUTPUT = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  adderStrobes_t                    strobes,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] aIn,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] bIn,
  input  logic                             carryIn,
  output logic [DIGIT_BITS*NUM_DIGITS-1:0] sumOut,
  output logic                             carryOut
);
  localparam int WIDTH = DIGIT_BITS * NUM_DIGITS;

  logic [NUM_DIGITS:0] carryChain;
  logic [WIDTH-1:0]    sumComb;

  assign carryChain[0] = carryIn;

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      logic [3:0] aDig, bDig, rDig;
      assign aDig = aIn[DIGIT_BITS*k +: DIGIT_BITS];
      assign bDig = bIn[DIGIT_BITS*k +: DIGIT_BITS];

      bcd_digit_slice u_slice (
        .digA  (aDig),
        .digB  (bDig),
        .cIn   (carryChain[k]),
        .digSum(rDig),
        .cOut  (carryChain[k+1])
      );
      assign sumComb[DIGIT_BITS*k +: DIGIT_BITS] = rDig;

      // carry judged by magnitude, independent of the flag logic
      assert_digit_carry_R2: assert property (@(posedge clk) disable iff (!rstN)
        (aDig <= 4'd9 && bDig <= 4'd9) |->
        (carryChain[k+1] == ((5'(aDig) + 5'(bDig) + 5'(carryChain[k])) >= 5'd10)));
      assert_digit_value_R1: assert property (@(posedge clk) disable iff (!rstN)
        (aDig <= 4'd9 && bDig <= 4'd9) |->
        ((5'(rDig) + (carryChain[k+1] ? 5'd10 : 5'd0)) ==
         (5'(aDig) + 5'(bDig) + 5'(carryChain[k]))));
      assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rstN)
        (aDig <= 4'd9 && bDig <= 4'd9) |-> (rDig <= 4'd9));
    end

    if (REGISTER_OUTPUT) begin : g_reg
      logic [WIDTH-1:0] sumQ;
      logic             carryQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sumQ   <= '0;
          carryQ <= 1'b0;
        end else if (strobes.capture) begin
          sumQ   <= sumComb;
          carryQ <= carryChain[NUM_DIGITS];
        end
      end
      assign sumOut   = sumQ;
      assign carryOut = carryQ;

      assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.capture |=> ($stable(sumOut) && $stable(carryOut)));
    end else begin : g_comb
      assign sumOut   = sumComb;
      assign carryOut = carryChain[NUM_DIGITS];
    end
  endgenerate
endmodule

// File: rtl/bcd_adder_top.sv
module bcd_adder_top
  import bcd_adder_pkg::*;
#(
  parameter int NUM_DIGITS      = 3,
  parameter bit REGISTER_OUTPUT = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] aIn,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] bIn,
  input  logic                             carryIn,
  output logic [DIGIT_BITS*NUM_DIGITS-1:0] sumOut,
  output logic                             carryOut,
  output logic                             outValid
);
  adderStrobes_t strobes;

  bcd_adder_ctrl #(.REGISTER_OUTPUT(REGISTER_OUTPUT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  bcd_adder_datapath #(
    .NUM_DIGITS     (NUM_DIGITS),
    .REGISTER_OUTPUT(REGISTER_OUTPUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .carryIn (carryIn),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );
endmodule

// File: tb/tb_bcd_adder_top.sv
module tb_bcd_adder_top;
  localparam int ND = 3;
  localparam int W  = 4 * ND;
  localparam int NV = 12;
  // fields: a, b, cin, expected sum, expected carry
  localparam int VW = W + W + 1 + W + 1;
  localparam logic [VW-1:0] VECS [NV] = '{
    {12'h000, 12'h000, 1'b0, 12'h000, 1'b0},  // R1 zero
    {12'h247, 12'h538, 1'b0, 12'h785, 1'b0},  // R3 low digit carries
    {12'h007, 12'h006, 1'b0, 12'h013, 1'b0},  // R2 7+6
    {12'h999, 12'h001, 1'b0, 12'h000, 1'b1},  // R3 full ripple
    {12'h999, 12'h999, 1'b1, 12'h999, 1'b1},  // R2 total 19
    {12'h123, 12'h456, 1'b0, 12'h579, 1'b0},  // R1 no adjustment
    {12'h004, 12'h005, 1'b1, 12'h010, 1'b0},  // R4 carry-in pushes to 10
    {12'h500, 12'h500, 1'b0, 12'h000, 1'b1},  // R5 top digit carry
    {12'h099, 12'h000, 1'b1, 12'h100, 1'b0},  // R4 carry-in ripples
    {12'h458, 12'h542, 1'b0, 12'h000, 1'b1},  // R5 all digits carry
    {12'h009, 12'h000, 1'b0, 12'h009, 1'b0},  // R1 boundary 9
    {12'h005, 12'h005, 1'b0, 12'h010, 1'b0}   // R2 boundary 10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic carryOut, outValid;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_adder_top #(.NUM_DIGITS(ND)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
    .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut), .outValid(outValid)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkDigits(input string req);
    logic bad = 1'b0;
    for (int k = 0; k < ND; k++) if (sumOut[4*k +: 4] > 4'd9) bad = 1'b1;
    check(req, {{W{1'b0}}, bad}, '0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] keepSum;
    logic keepCarry;
    repeat (3) @(negedge clk);
    check("R8 reset", {sumOut, carryOut}, '0);
    check("R8 reset valid", {{W{1'b0}}, outValid}, '0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {aIn, bIn, carryIn} = VECS[i][VW-1 -: (2*W+1)];
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R1/R2/R3/R4/R5 vector %0d", i),
            {sumOut, carryOut}, VECS[i][W:0]);
      check("R6 valid after capture", {{W{1'b0}}, outValid}, {{W{1'b0}}, 1'b1});
      checkDigits("R9 digit range");
    end

    // R7: change operands without capture
    keepSum = sumOut; keepCarry = carryOut;
    @(negedge clk);
    aIn = 12'h111; bIn = 12'h222; carryIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 hold", {sumOut, carryOut}, {keepSum, keepCarry});
    check("R6 valid low without capture", {{W{1'b0}}, outValid}, '0);

    // R6: latency of one edge for a fresh value
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 captured 111+222+1", {sumOut, carryOut}, {12'h334, 1'b0});

    // R8: reset in mid-run
    inValid = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check("R8 mid-run reset", {sumOut, carryOut}, '0);
    check("R8 mid-run reset valid", {{W{1'b0}}, outValid}, '0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule